// File: doc/BRIEF.md
# CD Sector Stream Generator

The block produces one synthetic raw CD sector as a byte stream, so that a sector decoder can be exercised without any disc data behind it. A start pulse captures an absolute sector number and a mode byte. The block turns the sector number into a minute:second:frame address, using 75 frames per second and 60 seconds per minute, and then streams 2352 bytes over a valid/ready interface. The final byte carries a last marker.

Each sector opens with a 12-byte sync field: a zero byte, ten 0xFF bytes and another zero byte. A 4-byte header follows, holding the minute, second and frame as two-digit BCD and then the captured mode byte. Every later byte is zero and stands in for user data and correction fields. The address is converted once per sector by a shared bit-serial divider that runs three passes, dividing by 75, then 60, then 100. The BCD result is packed into registers before the first byte goes out.

The controller is a state machine with six states:
- ST_IDLE waits for start.
- ST_DIV_FRAME divides the sector number by 75. The remainder is the frame.
- ST_DIV_SEC divides that quotient by 60. The remainder is the second.
- ST_DIV_MIN divides the resulting minute count by 100, so the minute wraps modulo 100.
- ST_PACK converts the three remainders to BCD.
- ST_EMIT streams the bytes.

The transitions are:
- ST_IDLE→ST_DIV_FRAME on start.
- Each divide state moves to the next state when the divider reports done.
- ST_DIV_MIN→ST_PACK.
- ST_PACK→ST_EMIT unconditionally.
- ST_EMIT→ST_IDLE when the last byte is accepted.

Top module: `cdsec_gen`

## Requirements
- R1: After reset, or after a reset applied mid-sector, out_valid and out_last are 0 until a new start is accepted.
- R2: Byte offset 0 and byte offset 11 are 0x00, and offsets 1 to 10 are 0xFF.
- R3: Offset 12 is the minute, computed as (N / 4500) mod 100, in BCD with the tens digit in bits 7:4 and the units digit in bits 3:0. Here N is the captured sector number.
- R4: Offset 13 is the second, computed as (N / 75) mod 60, in BCD with the same nibble layout.
- R5: Offset 14 is the frame, computed as N mod 75, in BCD with the same nibble layout.
- R6: Offset 15 is the value of mode_byte sampled on the clock edge that accepts start.
- R7: Every byte from offset 16 to offset 2351 is 0x00.
- R8: A sector is exactly 2352 accepted bytes. out_last is 1 only on offset 2351, and out_valid falls on the cycle after that byte is accepted.
- R9: The offset advances only on a cycle with out_valid and out_ready both 1. While out_ready is 0, out_data and out_last hold their values.
- R10: A start pulse is ignored while the block is not in ST_IDLE, whether it is converting or emitting. Such a pulse changes neither the sector in progress nor anything afterwards.
- R11: out_valid rises no more than 3*SECTOR_W+4 clock cycles after the edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only in ST_IDLE |
| sector_num | input | SECTOR_W | Absolute sector number, sampled with start |
| mode_byte | input | 8 | Header mode byte, sampled with start (normally 1) |
| out_valid | output | 1 | A sector byte is presented |
| out_ready | input | 1 | The consumer accepts the byte this cycle |
| out_data | output | 8 | Sector byte |
| out_last | output | 1 | Marks offset 2351 |

## Verification
The assertions assume a consumer that may lower out_ready at any time. They also assume that start arrives only as a pulse, with sector_num and mode_byte meaningful on the accepting edge alone. The bench drives start for a single cycle and then scrambles sector_num, so any late sampling of sector_num would show up. It injects extra start pulses during conversion and in the middle of emission, and it varies the out_ready stall patterns between sectors. All inputs change on the falling edge, so every sampled value is settled.

// File: rtl/cdsec_pkg.sv
package cdsec_pkg;

    localparam int SECTOR_BYTES   = 2352;
    localparam int FRAMES_PER_SEC = 75;
    localparam int SECS_PER_MIN   = 60;
    localparam int MIN_WRAP       = 100;

    localparam int OFS_FF_FIRST = 1;
    localparam int OFS_FF_LAST  = 10;
    localparam int OFS_MIN      = 12;
    localparam int OFS_SEC      = 13;
    localparam int OFS_FRM      = 14;
    localparam int OFS_MODE     = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV_FRAME,
        ST_DIV_SEC,
        ST_DIV_MIN,
        ST_PACK,
        ST_EMIT
    } gen_state_t;

    typedef struct packed {
        logic [7:0] minute;
        logic [7:0] second;
        logic [7:0] frame;
        logic [7:0] mode;
    } hdr_t;

    function automatic logic [7:0] to_bcd2(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v - 7'(tens * 7'd10);
        return {tens[3:0], ones[3:0]};
    endfunction

endpackage

// File: rtl/cdsec_div.sv
module cdsec_div #(
    parameter int DVD_W = 19,
    parameter int DSR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DSR_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [DVD_W-1:0] quotient,
    output logic [DSR_W-1:0] remainder
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] shreg;
    logic [DSR_W-1:0] rem;
    logic [CNT_W-1:0] cnt;
    logic [DSR_W:0]   trial;
    logic [DSR_W:0]   diff;
    logic             ge;

    assign trial = {rem, shreg[DVD_W-1]};
    assign ge    = trial >= {1'b0, divisor};
    assign diff  = trial - {1'b0, divisor};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            rem   <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else if (start) begin
            shreg <= dividend;
            rem   <= '0;
            cnt   <= CNT_W'(DVD_W);
            busy  <= 1'b1;
            done  <= 1'b0;
        end else if (busy) begin
            shreg <= {shreg[DVD_W-2:0], ge};
            rem   <= ge ? diff[DSR_W-1:0] : trial[DSR_W-1:0];
            cnt   <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign quotient  = shreg;
    assign remainder = rem;

    // partial remainder always below the divisor, basis of R3/R4/R5 fields
    assert_rem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem < divisor));

    assert_divisor_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(divisor));

endmodule

// File: rtl/cdsec_emit.sv
module cdsec_emit
    import cdsec_pkg::*;
#(
    parameter int NBYTES = SECTOR_BYTES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       ready,
    input  hdr_t       hdr,
    output logic [7:0] data,
    output logic       last,
    output logic       fire
);
    localparam int OFF_W = $clog2(NBYTES);

    logic [OFF_W-1:0] off;

    assign fire = active && ready;
    assign last = active && (off == OFF_W'(NBYTES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off <= '0;
        end else if (!active) begin
            off <= '0;
        end else if (fire) begin
            off <= last ? '0 : off + OFF_W'(1);
        end
    end

    always_comb begin
        data = 8'h00;
        if (off >= OFF_W'(OFS_FF_FIRST) && off <= OFF_W'(OFS_FF_LAST))
            data = 8'hFF;
        else if (off == OFF_W'(OFS_MIN))
            data = hdr.minute;
        else if (off == OFF_W'(OFS_SEC))
            data = hdr.second;
        else if (off == OFF_W'(OFS_FRM))
            data = hdr.frame;
        else if (off == OFF_W'(OFS_MODE))
            data = hdr.mode;
    end

    assert_offset_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        off <= OFF_W'(NBYTES - 1));

    assert_offset_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !ready) |=> (off == $past(off)));

endmodule

// File: rtl/cdsec_gen.sv
module cdsec_gen
    import cdsec_pkg::*;
#(
    parameter int SECTOR_W = 19
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SECTOR_W-1:0] sector_num,
    input  logic [7:0]          mode_byte,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [7:0]          out_data,
    output logic                out_last
);
    localparam int DSR_W = 7;

    gen_state_t state_q, state_d;

    logic                div_start, div_busy, div_done;
    logic [SECTOR_W-1:0] div_dividend, div_quot;
    logic [DSR_W-1:0]    div_divisor, div_rem;
    logic [DSR_W-1:0]    frame_bin, sec_bin, min_bin;
    logic [7:0]          mode_q;
    hdr_t                hdr_q;
    logic                emit_fire, emit_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start)                  state_d = ST_DIV_FRAME;
            ST_DIV_FRAME: if (div_done)               state_d = ST_DIV_SEC;
            ST_DIV_SEC:   if (div_done)               state_d = ST_DIV_MIN;
            ST_DIV_MIN:   if (div_done)               state_d = ST_PACK;
            ST_PACK:                                  state_d = ST_EMIT;
            ST_EMIT:      if (emit_fire && emit_last) state_d = ST_IDLE;
            default:                                  state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        out_valid    = (state_q == ST_EMIT);
        div_start    = 1'b0;
        div_dividend = div_quot;
        div_divisor  = DSR_W'(FRAMES_PER_SEC);
        unique case (state_q)
            ST_IDLE: begin
                div_start    = start;
                div_dividend = sector_num;
            end
            ST_DIV_FRAME: div_start = div_done;
            ST_DIV_SEC: begin
                div_start   = div_done;
                div_divisor = DSR_W'(SECS_PER_MIN);
            end
            ST_DIV_MIN:   div_divisor = DSR_W'(MIN_WRAP);
            default: ;
        endcase
    end

    // address capture and BCD packing, once per sector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_bin <= '0;
            sec_bin   <= '0;
            min_bin   <= '0;
            mode_q    <= '0;
            hdr_q     <= '0;
        end else begin
            if (state_q == ST_IDLE && start)        mode_q    <= mode_byte;
            if (state_q == ST_DIV_FRAME && div_done) frame_bin <= div_rem;
            if (state_q == ST_DIV_SEC && div_done)   sec_bin   <= div_rem;
            if (state_q == ST_DIV_MIN && div_done)   min_bin   <= div_rem;
            if (state_q == ST_PACK) begin
                hdr_q.minute <= to_bcd2(min_bin);
                hdr_q.second <= to_bcd2(sec_bin);
                hdr_q.frame  <= to_bcd2(frame_bin);
                hdr_q.mode   <= mode_q;
            end
        end
    end

    cdsec_div #(.DVD_W(SECTOR_W), .DSR_W(DSR_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (div_start),
        .dividend  (div_dividend),
        .divisor   (div_divisor),
        .busy      (div_busy),
        .done      (div_done),
        .quotient  (div_quot),
        .remainder (div_rem)
    );

    cdsec_emit #(.NBYTES(SECTOR_BYTES)) u_emit (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (out_valid),
        .ready  (out_ready),
        .hdr    (hdr_q),
        .data   (out_data),
        .last   (emit_last),
        .fire   (emit_fire)
    );

    assign out_last = emit_last;

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_last_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_sector_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    assert_no_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && out_last)) |=> out_valid);

    assert_hdr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(hdr_q));

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> !div_busy);

endmodule

// File: tb/test_cdsec_gen.sv
module test_cdsec_gen;
    localparam int SW      = 19;
    localparam int NBYTES  = 2352;
    localparam int LAT_MAX = 3 * SW + 5; // counted in falling edges from the start edge
    localparam int NV      = 8;
    localparam logic [SW+7:0] VECS [NV] = '{
        {19'd0,      8'h01},
        {19'd74,     8'h01},
        {19'd75,     8'h02},
        {19'd4499,   8'h01},
        {19'd4500,   8'h00},
        {19'd449999, 8'h01},
        {19'd450000, 8'h01},
        {19'd524287, 8'hA5}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [SW-1:0] sector_num = '0;
    logic [7:0]    mode_byte = 8'h01;
    logic          out_valid, out_ready, out_last;
    logic [7:0]    out_data;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    cdsec_gen #(.SECTOR_W(SW)) i_cdsec_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .sector_num(sector_num),
        .mode_byte(mode_byte), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] exp_byte(input int off, input int s, input logic [7:0] m);
        if (off >= 1 && off <= 10) return 8'hFF;
        if (off == 12) return bcd((s / 4500) % 100);
        if (off == 13) return bcd((s / 75) % 60);
        if (off == 14) return bcd(s % 75);
        if (off == 15) return m;
        return 8'h00;
    endfunction

    // runs one sector; stall selects an out_ready pattern, inject pulses stray starts
    task automatic run_sector(input int s, input logic [7:0] m, input int stall, input logic inject);
        int lat = 0;
        int off = 0;
        int cyc = 0;
        logic [7:0] prev_d = 8'h00;
        logic prev_stall = 1'b0;
        logic prev_last = 1'b0;
        int sync_bad = 0, fill_bad = 0, last_bad = 0, hold_bad = 0;
        logic broke = 1'b0;
        @(negedge clk);
        sector_num = SW'(s);
        mode_byte  = m;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        sector_num = SW'(s ^ 12345);
        mode_byte  = ~m;
        while (!out_valid && lat < 200) begin
            if (inject && lat == 5) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        check(lat <= LAT_MAX - 1, "R11 latency", lat, LAT_MAX - 1);
        while (off < NBYTES && !broke) begin
            logic rdy;
            if (!out_valid) begin
                check(1'b0, "R8 valid dropped mid-sector", off, NBYTES);
                broke = 1'b1;
            end else begin
                if (prev_stall && (out_data !== prev_d || out_last !== prev_last)) hold_bad++;
                if (off == 12) check(out_data == exp_byte(off, s, m), "R3 minute", out_data, exp_byte(off, s, m));
                else if (off == 13) check(out_data == exp_byte(off, s, m), "R4 second", out_data, exp_byte(off, s, m));
                else if (off == 14) check(out_data == exp_byte(off, s, m), "R5 frame", out_data, exp_byte(off, s, m));
                else if (off == 15) check(out_data == m, "R6 mode", out_data, m);
                else if (off < 12) begin
                    if (out_data !== exp_byte(off, s, m)) sync_bad++;
                end else if (out_data !== 8'h00) fill_bad++;
                if (out_last !== (off == NBYTES - 1)) last_bad++;
                rdy = (stall == 0) ? 1'b1 : ((cyc % (stall + 2)) != 0);
                out_ready = rdy;
                prev_d = out_data;
                prev_last = out_last;
                prev_stall = !rdy;
                if (inject && off == 100) begin
                    start = 1'b1;
                    sector_num = SW'(777);
                end
                @(negedge clk);
                start = 1'b0;
                cyc++;
                if (rdy) off++;
            end
        end
        out_ready = 1'b0;
        check(sync_bad == 0, "R2 sync bytes", sync_bad, 0);
        check(fill_bad == 0, "R7 zero fill", fill_bad, 0);
        check(last_bad == 0, "R8 last marker", last_bad, 0);
        check(hold_bad == 0, "R9 stall hold", hold_bad, 0);
        check(out_valid == 1'b0, "R8 valid low after 2352 bytes", out_valid, 0);
        begin
            int late = 0;
            for (int k = 0; k < 80; k++) begin
                if (out_valid) late++;
                @(negedge clk);
            end
            check(late == 0, "R10 stray start not queued", late, 0);
        end
    endtask

    initial begin
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_last == 1'b0, "R1 reset outputs", {out_valid, out_last}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_last == 1'b0, "R1 idle after reset", {out_valid, out_last}, 0);

        for (int i = 0; i < NV; i++)
            run_sector(int'(VECS[i][SW+7:8]), VECS[i][7:0], i % 3, (i % 2) == 1);

        // mid-sector reset
        @(negedge clk);
        sector_num = SW'(12345);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        out_ready = 1'b1;
        repeat (120) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(out_valid == 1'b0 && out_last == 1'b0, "R1 reset mid-sector", {out_valid, out_last}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R1 stays idle after reset", out_valid, 0);
        run_sector(1, 8'h01, 0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule